// File: doc/BRIEF.md
# Radio Message DMA Engine

This block moves whole radio messages between shared RAM and a bit-serial radio line without any CPU involvement per byte or per bit. To transmit, the CPU issues one command carrying the RAM address of a message buffer. The engine reads the buffer through its memory master port and serializes it behind a fixed 16-bit start pattern. It then raises a one-cycle completion pulse.

On the receive side the engine oversamples the serial input. It re-aligns its bit sampling to every edge of the incoming line and hunts for the start pattern. Once the pattern is found, it assembles bytes and writes them into one of two receive buffers that it owns, alternating between them. A one-cycle arrival pulse carries the buffer's address. Byte 0 of every buffer holds the payload length. No channel coding is applied, so bits travel raw. The engine is half duplex: the receiver is idle while a transmission runs.

Top module: `radio_msg_dma`

## Requirements
- R1: After reset, tx_en, tx_bit, tx_done, rx_done, mem_req and busy_err are all 0, and the next receive buffer is RXA (0x80).
- R2: A cmd_valid sampled while the engine is idle is accepted. In the next cycle tx_en is 1 and a memory read (mem_req=1, mem_we=0) is issued at mem_addr = cmd_ptr.
- R3: The transmitted frame is the 16-bit start pattern 0xD391, sent bit 0 first, followed by the message bytes in increasing address order, each sent LSB first. Every bit is held for OVS=8 clock cycles, and the first bit appears in the cycle after acceptance.
- R4: Byte 0 of the buffer is the payload length L. The engine transfers L+1 bytes. A stored length above 36 is treated as 36, and 36 is sent as byte 0.
- R5: tx_done is a one-cycle pulse in the cycle right after the last bit period. tx_en is 0 in that cycle.
- R6: A cmd_valid that arrives while a transmission runs or a message is being received is ignored: the current frame is unchanged and no new transmission starts. It also sets busy_err, which stays 1 until reset.
- R7: The receiver writes nothing to memory and raises no arrival until the last 16 sampled bits equal 0xD391, with the first-received bit in bit 0.
- R8: Receive timing is recovered from the line. The sample counter restarts on every transition, and each bit is sampled OVS/2 counts later. Frames are received correctly at any start phase and with bit lengths alternating between 7 and 9 cycles.
- R9: Received bytes are written in order to consecutive addresses from the buffer base, L+1 bytes in total. A received length above 36 is stored as 36, and the excess bytes are not stored.
- R10: rx_done is a one-cycle pulse that occurs together with the write of the last byte. At that point rx_ptr holds that buffer's base. Successive messages alternate between RXA (0x80) and RXB (0xC0).
- R11: While tx_en is 1, the receiver ignores rx_in: nothing is written and no arrival is raised.
- R12: Memory accesses are single-cycle requests. Read data is taken from mem_rdata in the cycle after the request.

Parameters used by the requirements: OVS=8, start pattern 0xD391, maximum length 36, RXA=0x80, RXB=0xC0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Send command strobe |
| cmd_ptr | input | AW | RAM address of the message to send |
| tx_done | output | 1 | One-cycle transmit completion pulse |
| busy_err | output | 1 | Sticky flag: a command was rejected |
| rx_done | output | 1 | One-cycle message arrival pulse |
| rx_ptr | output | AW | Base address of the buffer just filled |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after a read request |
| tx_en | output | 1 | High while a frame is on the line |
| tx_bit | output | 1 | Serial transmit data |
| rx_in | input | 1 | Serial receive data |

## Verification
The bench drives a send command that is sampled at one edge. It expects bit k of the frame in the eight cycles that start k*8 cycles after that edge. It expects tx_done exactly 8 cycles after the last bit begins. It compares tx_en and tx_bit at every falling edge against a bit queue built from its own memory image. On receive, the line passes through one input register before any edge detection or sampling, so the arrival is due a few cycles after the middle of the final bit. The bench therefore watches rx_done over the whole frame plus a margin of idle bits, and requires exactly one pulse with the right pointer. A rejected command is followed two cycles later by checks that tx_en did not rise and that busy_err is set.

// File: rtl/radio_msg_dma.sv
module radio_msg_dma #(
  parameter int AW = 8,
  parameter int OVS = 8,
  parameter logic [15:0] SYNC = 16'hD391,
  parameter int MAX_LEN = 36,
  parameter logic [AW-1:0] RXA = 8'h80,
  parameter logic [AW-1:0] RXB = 8'hC0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_ptr,
  output logic          tx_done,
  output logic          busy_err,
  output logic          rx_done,
  output logic [AW-1:0] rx_ptr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          tx_en,
  output logic          tx_bit,
  input  logic          rx_in
);
  localparam int PW = $clog2(OVS);
  localparam int LW = $clog2(MAX_LEN + 1);
  localparam logic [PW-1:0] PH_LAST = PW'(OVS - 1);
  localparam logic [PW-1:0] PH_MID = PW'(OVS / 2);

  function automatic logic [LW-1:0] clamp_len(input logic [7:0] b);
    return (b > 8'(MAX_LEN)) ? LW'(MAX_LEN) : b[LW-1:0];
  endfunction

  // transmit state
  logic          tx_act, need, rd_pend, hold_v, first;
  logic [PW-1:0] tph;
  logic [15:0]   tx_sr;
  logic [4:0]    tx_nb;
  logic [7:0]    hold;
  logic [AW-1:0] tx_addr;
  logic [LW-1:0] tx_left;

  // receive state
  logic          rx_s, rx_p, rx_on, rx_first, rx_sel, wr_pend;
  logic [PW-1:0] rcnt;
  logic [15:0]   rx_win;
  logic [7:0]    rx_byte, wr_data;
  logic [2:0]    rx_nb;
  logic [LW-1:0] rx_left;
  logic [AW-1:0] rx_idx, rx_base, wr_addr;

  logic busy, accept, edge_s, strobe, rx_last;
  logic [15:0] win_n;
  logic [7:0]  byte_n;
  logic [LW-1:0] rx_len;

  assign busy    = tx_act | rx_on;
  assign accept  = cmd_valid & ~busy;
  assign edge_s  = rx_s ^ rx_p;
  assign strobe  = ~edge_s & (rcnt == PH_MID);
  assign win_n   = {rx_s, rx_win[15:1]};
  assign byte_n  = {rx_s, rx_byte[7:1]};
  assign rx_len  = clamp_len(byte_n);
  assign rx_last = rx_first ? (rx_len == '0) : (rx_left == LW'(1));

  assign tx_en     = tx_act;
  assign tx_bit    = tx_act & tx_sr[0];
  assign mem_req   = (tx_act & need) | wr_pend;
  assign mem_we    = wr_pend;
  assign mem_addr  = wr_pend ? wr_addr : tx_addr;
  assign mem_wdata = wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_act <= 1'b0; need <= 1'b0; rd_pend <= 1'b0; hold_v <= 1'b0;
      first <= 1'b0; tph <= '0; tx_sr <= '0; tx_nb <= '0; hold <= '0;
      tx_addr <= '0; tx_left <= '0; tx_done <= 1'b0; busy_err <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      if (cmd_valid && busy) busy_err <= 1'b1;
      if (accept) begin
        tx_act <= 1'b1; need <= 1'b1; rd_pend <= 1'b0; hold_v <= 1'b0;
        first <= 1'b1; tph <= '0; tx_sr <= SYNC; tx_nb <= 5'd16;
        tx_addr <= cmd_ptr; tx_left <= '0;
      end else if (tx_act) begin
        if (need) begin
          need <= 1'b0;
          rd_pend <= 1'b1;
          tx_addr <= tx_addr + 1'b1;
        end
        if (rd_pend) begin
          rd_pend <= 1'b0;
          hold_v <= 1'b1;
          first <= 1'b0;
          if (first) begin
            hold <= 8'(clamp_len(mem_rdata));
            tx_left <= clamp_len(mem_rdata);
          end else begin
            hold <= mem_rdata;
          end
        end
        tph <= (tph == PH_LAST) ? '0 : tph + 1'b1;
        if (tph == PH_LAST) begin
          if (tx_nb != 5'd1) begin
            tx_sr <= tx_sr >> 1;
            tx_nb <= tx_nb - 1'b1;
          end else if (hold_v) begin
            tx_sr <= {8'h00, hold};
            tx_nb <= 5'd8;
            hold_v <= 1'b0;
            if (tx_left != '0) begin
              need <= 1'b1;
              tx_left <= tx_left - 1'b1;
            end
          end else begin
            tx_act <= 1'b0;
            tx_done <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_s <= 1'b0; rx_p <= 1'b0; rcnt <= '0; rx_win <= '0; rx_on <= 1'b0;
      rx_first <= 1'b0; rx_sel <= 1'b0; wr_pend <= 1'b0; rx_byte <= '0;
      wr_data <= '0; rx_nb <= '0; rx_left <= '0; rx_idx <= '0;
      rx_base <= '0; wr_addr <= '0; rx_done <= 1'b0; rx_ptr <= '0;
    end else begin
      rx_s <= rx_in;
      rx_p <= rx_s;
      rcnt <= edge_s ? '0 : ((rcnt == PH_LAST) ? '0 : rcnt + 1'b1);
      rx_done <= 1'b0;
      wr_pend <= 1'b0;
      if (tx_act) begin
        rx_win <= '0;
      end else if (strobe) begin
        if (!rx_on) begin
          if (win_n == SYNC) begin
            rx_on <= 1'b1;
            rx_win <= '0;
            rx_nb <= '0;
            rx_first <= 1'b1;
            rx_idx <= rx_sel ? RXB : RXA;
            rx_base <= rx_sel ? RXB : RXA;
          end else begin
            rx_win <= win_n;
          end
        end else begin
          rx_byte <= byte_n;
          rx_nb <= rx_nb + 1'b1;
          if (rx_nb == 3'd7) begin
            wr_pend <= 1'b1;
            wr_addr <= rx_idx;
            rx_idx <= rx_idx + 1'b1;
            rx_first <= 1'b0;
            wr_data <= rx_first ? 8'(rx_len) : byte_n;
            rx_left <= rx_first ? rx_len : rx_left - 1'b1;
            if (rx_last) begin
              rx_on <= 1'b0;
              rx_done <= 1'b1;
              rx_ptr <= rx_base;
              rx_sel <= ~rx_sel;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/radio_msg_dma_chk.sv
module radio_msg_dma_chk #(
  parameter int AW = 8,
  parameter int PW = 3,
  parameter logic [AW-1:0] RXA = 8'h80,
  parameter logic [AW-1:0] RXB = 8'hC0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [AW-1:0] cmd_ptr,
  input logic          busy,
  input logic          tx_en,
  input logic          tx_bit,
  input logic [PW-1:0] tph,
  input logic          tx_done,
  input logic          busy_err,
  input logic          rx_done,
  input logic [AW-1:0] rx_ptr,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);
  a_r2_accept_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> (tx_en && mem_req && !mem_we && mem_addr == $past(cmd_ptr)));
  a_r3_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tph != '0) |-> $stable(tx_bit));
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);
  a_r5_done_ends_tx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (!tx_en && $past(tx_en)));
  a_r6_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy) |=> busy_err);
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    busy_err |=> busy_err);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);
  a_r10_ptr_base: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> (rx_ptr == RXA || rx_ptr == RXB));
  a_r10_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> (mem_req && mem_we));
  a_r11_no_write_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> !(mem_req && mem_we));
endmodule

bind radio_msg_dma radio_msg_dma_chk #(.AW(AW), .PW(PW), .RXA(RXA), .RXB(RXB)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ptr(cmd_ptr), .busy(busy),
  .tx_en(tx_en), .tx_bit(tx_bit), .tph(tph), .tx_done(tx_done), .busy_err(busy_err),
  .rx_done(rx_done), .rx_ptr(rx_ptr), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr)
);

// File: tb/sim_radio_msg_dma.sv
module sim_radio_msg_dma;
  localparam logic [15:0] SYNC = 16'hD391;
  localparam logic [7:0] RXA = 8'h80, RXB = 8'hC0;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, rx_in = 1'b0;
  logic [7:0] cmd_ptr = '0, mem_rdata = '0, rx_ptr, mem_addr, mem_wdata;
  logic tx_done, busy_err, rx_done, mem_req, mem_we, tx_en, tx_bit;

  logic [7:0] mem [0:255];
  int n_chk = 0, n_fail = 0, wr_cnt = 0;
  logic txq[$];
  logic rxq[$];
  logic [7:0] rxb[$];
  logic [7:0] exp_base = RXA;

  always #10 clk = ~clk;

  radio_msg_dma u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ptr(cmd_ptr),
    .tx_done(tx_done), .busy_err(busy_err), .rx_done(rx_done), .rx_ptr(rx_ptr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .tx_en(tx_en), .tx_bit(tx_bit), .rx_in(rx_in)
  );

  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end else if (mem_req) begin
      mem_rdata <= mem[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampl(input logic [7:0] b);
    return (b > 36) ? 36 : int'(b);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_base = RXA;
  endtask

  task automatic send_check(input logic [7:0] ptr, input bit inject);
    int n, errs, l, first_bad;
    txq.delete();
    for (int i = 0; i < 16; i++) txq.push_back(SYNC[i]);
    l = clampl(mem[ptr]);
    for (int k = 0; k <= l; k++) begin
      logic [7:0] b;
      b = (k == 0) ? 8'(l) : mem[8'(ptr + k)];
      for (int i = 0; i < 8; i++) txq.push_back(b[i]);
    end
    n = txq.size();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_ptr = ptr;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(tx_en && mem_req && !mem_we && mem_addr == ptr, "R2 start read", int'(mem_addr), int'(ptr));
    errs = 0; first_bad = -1;
    for (int j = 0; j <= 8 * n; j++) begin
      if (j > 0) @(negedge clk);
      if (inject && j == 50) begin cmd_valid = 1'b1; cmd_ptr = 8'h40; end
      if (inject && j == 51) cmd_valid = 1'b0;
      if (j < 8 * n) begin
        if (!tx_en || tx_done || tx_bit !== txq[j / 8]) begin
          errs++;
          if (first_bad < 0) first_bad = j;
        end
      end else begin
        chk(tx_done && !tx_en, "R5 done after last bit", int'(tx_done), 1);
      end
    end
    chk(errs == 0, "R3 R4 frame bits", first_bad, -1);
    @(negedge clk);
    chk(!tx_done && !tx_en, "R5 done one cycle", int'(tx_done), 0);
  endtask

  task automatic build_rx();
    rxq.delete();
    for (int i = 0; i < 24; i++) rxq.push_back(1'b0);
    for (int i = 0; i < 16; i++) rxq.push_back(SYNC[i]);
    foreach (rxb[k]) for (int i = 0; i < 8; i++) rxq.push_back(rxb[k][i]);
    for (int i = 0; i < 16; i++) rxq.push_back(1'b0);
  endtask

  task automatic play_rx(input bit jitter);
    foreach (rxq[k]) begin
      rx_in = rxq[k];
      repeat (jitter ? ((k % 2) ? 9 : 7) : 8) @(negedge clk);
    end
    rx_in = 1'b0;
  endtask

  task automatic rx_check(input bit jitter, input bit inject, input string tag);
    int w0, dn, l, bad;
    logic [7:0] p;
    build_rx();
    w0 = wr_cnt; dn = 0; p = '0;
    fork
      play_rx(jitter);
      begin
        for (int c = 0; c < rxq.size() * 9 + 40; c++) begin
          @(negedge clk);
          if (rx_done) begin dn++; p = rx_ptr; end
          if (inject && c == 8 * 44) begin cmd_valid = 1'b1; cmd_ptr = 8'h10; end
          if (inject && c == 8 * 44 + 1) cmd_valid = 1'b0;
          if (inject && c == 8 * 44 + 2)
            chk(!tx_en && busy_err, "R6 reject during receive", int'(tx_en), 0);
        end
      end
    join
    l = clampl(rxb[0]);
    chk(dn == 1 && p == exp_base, {tag, " R10 arrival pointer"}, int'(p), int'(exp_base));
    chk(wr_cnt - w0 == l + 1, {tag, " R9 write count"}, wr_cnt - w0, l + 1);
    bad = 0;
    for (int k = 0; k <= l; k++)
      if (mem[8'(exp_base + k)] !== ((k == 0) ? 8'(l) : rxb[k])) bad++;
    chk(bad == 0, {tag, " R9 buffer contents"}, bad, 0);
    exp_base = (exp_base == RXA) ? RXB : RXA;
  endtask

  bit finished = 1'b0;

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int w0, dn;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    mem[8'h10] = 8'd3; mem[8'h20] = 8'd0; mem[8'h30] = 8'd36;
    mem[8'h60] = 8'd50; mem[8'h08] = 8'd4;
    do_reset();
    @(negedge clk);
    chk(!tx_en && !tx_bit && !tx_done && !rx_done && !mem_req && !busy_err,
        "R1 reset state", int'(tx_en), 0);

    send_check(8'h10, 1'b0);   // R2 R3 R12
    send_check(8'h20, 1'b0);   // R4 zero length
    send_check(8'h30, 1'b0);   // R4 maximum length
    send_check(8'h60, 1'b0);   // R4 clamp above 36
    chk(!busy_err, "R6 no error without overlap", int'(busy_err), 0);
    send_check(8'h08, 1'b1);   // R6 command during transmit
    chk(busy_err, "R6 busy_err set", int'(busy_err), 1);
    repeat (20) @(negedge clk);
    chk(busy_err, "R6 busy_err sticky", int'(busy_err), 1);
    do_reset();
    @(negedge clk);
    chk(!busy_err, "R1 busy_err cleared by reset", int'(busy_err), 0);

    // R7: line noise without start pattern
    rxq.delete();
    for (int i = 0; i < 80; i++) rxq.push_back(i[0] ? 1'b0 : 1'b1);
    for (int i = 0; i < 16; i++) rxq.push_back(1'b0);
    w0 = wr_cnt; dn = 0;
    fork
      play_rx(1'b0);
      for (int c = 0; c < 96 * 8 + 20; c++) begin @(negedge clk); if (rx_done) dn++; end
    join
    chk(wr_cnt == w0 && dn == 0, "R7 no capture without start pattern", wr_cnt - w0, 0);

    rxb.delete(); rxb = '{8'd3, 8'hA1, 8'h00, 8'hFF};
    repeat (3) @(negedge clk);
    rx_check(1'b0, 1'b0, "R9 basic");
    rxb.delete(); rxb = '{8'd5, 8'h0F, 8'hF0, 8'h33, 8'hCC, 8'h81};
    repeat (5) @(negedge clk);
    rx_check(1'b1, 1'b0, "R8 jittered");
    rxb.delete(); rxb.push_back(8'd40);
    for (int k = 1; k <= 36; k++) rxb.push_back(8'(k * 11 + 5));
    for (int k = 0; k < 4; k++) rxb.push_back(8'h00);
    rx_check(1'b0, 1'b0, "R9 clamp");

    // R11: start pattern on the line during transmit is ignored
    rxb.delete(); rxb = '{8'd2, 8'h5A, 8'hA5};
    build_rx();
    w0 = wr_cnt; dn = 0;
    fork
      send_check(8'h08, 1'b0);
      begin repeat (10) @(negedge clk); play_rx(1'b0); end
      for (int c = 0; c < 600; c++) begin @(negedge clk); if (rx_done) dn++; end
    join
    chk(wr_cnt == w0 && dn == 0, "R11 receive ignored during transmit", wr_cnt - w0, 0);

    rxb.delete(); rxb = '{8'd6, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    repeat (4) @(negedge clk);
    rx_check(1'b0, 1'b1, "R6 R10 second buffer");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule